// File: doc/BRIEF.md
# Serial Flash Chip-Select Timing Sequencer

This block frames each transfer of a quad serial flash master. It drives the active-low chip-select and the serial clock. Its internal clock runs at twice the serial clock rate, so every internal step is half a serial clock period. A requester presents a cycle count with a valid strobe. The sequencer pulls chip-select low and waits a programmable setup delay. It then produces the requested number of serial clock pulses and waits a programmable hold delay before it releases chip-select. After that it keeps the block busy for a programmable minimum deselect time before it takes the next request.

A 6-bit configuration word sets all three delays. Setup and hold each come in two lengths, half a serial clock or one and a half. The deselect time ranges from 1 to 16 serial clocks. The configuration can be changed only while the block is idle. Data shifting, commands and addressing belong to neighbouring logic.

Top module: `csseq_top`

## Requirements
- R1: After reset, chip-select is high and the serial clock, busy and done are low. The configuration word is 0x37: setup 1.5 cycles, hold 1.5 cycles, deselect 8 cycles.
- R2: When busy is low and a request with a non-zero count is presented, chip-select goes low and busy goes high on the next clock edge.
- R3: Configuration bit 5 sets the setup time. With 0, the first rising serial clock edge comes one internal step (half a serial clock) after chip-select falls. With 1, it comes three steps after.
- R4: A transfer with count N produces exactly N serial clock pulses. Each pulse is high for one step and separated from the next by one low step. The serial clock is low whenever chip-select is high.
- R5: Configuration bit 4 sets the hold time. With 0, chip-select rises one step after the last rising serial clock edge. With 1, it rises three steps after.
- R6: Configuration bits 3:0 hold a value F. Busy stays high for 2*(F+1) steps, counted from the step on which chip-select rises, and then falls.
- R7: Done is high for exactly one step, the step on which chip-select rises.
- R8: A request held while busy is accepted on the first edge after busy falls. For a request waiting at the end of a transfer, chip-select therefore stays high for 2*(F+1)+1 steps.
- R9: A request with a count of zero is ignored: chip-select stays high and busy stays low.
- R10: A configuration write takes effect only when it is made while busy is low and no request is being accepted in the same cycle. A write made while busy is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request strobe, held until busy is seen |
| reqCycles | input | CNT_W | Number of serial clock cycles for the transfer |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 6 | Configuration word: bit 5 setup, bit 4 hold, bits 3:0 deselect |
| busy | output | 1 | High from acceptance until the deselect time ends |
| done | output | 1 | One-step pulse as chip-select rises |
| csN | output | 1 | Active-low chip-select |
| sck | output | 1 | Serial clock, idles low |

## Verification
A wrong step counter or phase state shows up at once as a chip-select or clock edge one or two steps away from its expected position. It appears within the same transfer, so the bench compares every output on every step of each frame against a timeline computed from the count and configuration. A miscounted remaining-cycle register shows as an extra or missing clock pulse and a shifted release of chip-select. A corrupted configuration register or a wrongly accepted write only becomes visible on the next transfer, through changed setup, hold or deselect lengths. Held-off requests are measured by counting the steps between done and the next falling chip-select.

// File: rtl/csseq_pkg.sv
package csseq_pkg;

  localparam int GAP_SEL_W = 4;
  localparam int CFG_W     = GAP_SEL_W + 2;
  localparam int STEP_W    = GAP_SEL_W + 2;

  localparam logic [CFG_W-1:0] CFG_RESET = 6'h37;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLK,
    ST_HOLD,
    ST_GAP
  } seqState_t;

  // bit 5 setup length, bit 4 hold length, bits 3:0 deselect select
  typedef struct packed {
    logic                 setupLong;
    logic                 holdLong;
    logic [GAP_SEL_W-1:0] gapSel;
  } seqCfg_t;

  typedef struct packed {
    logic csAssert;
    logic csRelease;
    logic sckRise;
    logic sckFall;
    logic loadCount;
    logic cfgLoad;
  } seqStrobe_t;

endpackage

// File: rtl/csseq_datapath.sv
module csseq_datapath
  import csseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] reqCycles,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             busy,
  output seqCfg_t          cfg,
  output logic             cycZero,
  output logic             sckLvl,
  output logic             csN,
  output logic             sck,
  output logic             done
);

  logic [CNT_W-1:0] cycLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= seqCfg_t'(CFG_RESET);
      cycLeft <= '0;
      csN     <= 1'b1;
      sck     <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (strobe.cfgLoad) cfg <= seqCfg_t'(cfgWrData);

      if (strobe.loadCount)    cycLeft <= reqCycles;
      else if (strobe.sckRise) cycLeft <= cycLeft - CNT_W'(1);

      if (strobe.csAssert)       csN <= 1'b0;
      else if (strobe.csRelease) csN <= 1'b1;

      if (strobe.sckRise)      sck <= 1'b1;
      else if (strobe.sckFall) sck <= 1'b0;

      done <= strobe.csRelease;
    end
  end

  assign cycZero = (cycLeft == '0);
  assign sckLvl  = sck;

  // R4
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);

  // R7
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !$past(csN)));

  // R6
  busy_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> busy);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfg));

endmodule

// File: rtl/csseq_control.sv
module csseq_control
  import csseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCycles,
  input  logic             cfgWrEn,
  input  seqCfg_t          cfg,
  input  logic             cycZero,
  input  logic             sckLvl,
  output seqStrobe_t       strobe,
  output logic             busy
);

  seqState_t         state, nxtState;
  logic [STEP_W-1:0] stepCnt, nxtStep;
  logic              accept;
  logic [STEP_W-1:0] gapSteps;

  // 2*(F+1)-1 steps remain after the release step
  assign gapSteps = STEP_W'({cfg.gapSel, 1'b1});
  assign accept   = (state == ST_IDLE) && reqValid && (reqCycles != '0);

  always_comb begin
    nxtState = state;
    nxtStep  = stepCnt;
    strobe   = '0;
    strobe.cfgLoad = cfgWrEn && (state == ST_IDLE) && !accept;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          strobe.csAssert  = 1'b1;
          strobe.loadCount = 1'b1;
          nxtState = ST_SETUP;
          nxtStep  = cfg.setupLong ? STEP_W'(2) : '0;
        end
      end
      ST_SETUP: begin
        if (stepCnt == '0) begin
          strobe.sckRise = 1'b1;
          nxtState = ST_CLK;
        end else begin
          nxtStep = stepCnt - STEP_W'(1);
        end
      end
      ST_CLK: begin
        if (sckLvl) begin
          strobe.sckFall = 1'b1;
          if (cycZero) begin
            if (cfg.holdLong) begin
              nxtState = ST_HOLD;
              nxtStep  = STEP_W'(1);
            end else begin
              strobe.csRelease = 1'b1;
              nxtState = ST_GAP;
              nxtStep  = gapSteps;
            end
          end
        end else begin
          strobe.sckRise = 1'b1;
        end
      end
      ST_HOLD: begin
        if (stepCnt == '0) begin
          strobe.csRelease = 1'b1;
          nxtState = ST_GAP;
          nxtStep  = gapSteps;
        end else begin
          nxtStep = stepCnt - STEP_W'(1);
        end
      end
      ST_GAP: begin
        if (stepCnt == '0) nxtState = ST_IDLE;
        else               nxtStep  = stepCnt - STEP_W'(1);
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= nxtState;
      stepCnt <= nxtStep;
    end
  end

  assign busy = (state != ST_IDLE);

  // R2
  req_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqCycles != '0) |=> busy);

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqCycles == '0) |=> !busy);

  // R4
  rise_only_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sckRise |-> !sckLvl);

endmodule

// File: rtl/csseq_top.sv
module csseq_top
  import csseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCycles,
  input  logic             cfgWrEn,
  input  logic [5:0]       cfgWrData,
  output logic             busy,
  output logic             done,
  output logic             csN,
  output logic             sck
);

  seqStrobe_t strobe;
  seqCfg_t    cfg;
  logic       cycZero;
  logic       sckLvl;

  csseq_control #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCycles (reqCycles),
    .cfgWrEn   (cfgWrEn),
    .cfg       (cfg),
    .cycZero   (cycZero),
    .sckLvl    (sckLvl),
    .strobe    (strobe),
    .busy      (busy)
  );

  csseq_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqCycles (reqCycles),
    .cfgWrData (cfgWrData),
    .busy      (busy),
    .cfg       (cfg),
    .cycZero   (cycZero),
    .sckLvl    (sckLvl),
    .csN       (csN),
    .sck       (sck),
    .done      (done)
  );

endmodule

// File: tb/csseq_top_tb_top.sv
module csseq_top_tb_top;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [CNT_W-1:0] reqCycles = '0;
  logic             cfgWrEn = 1'b0;
  logic [5:0]       cfgWrData = '0;
  logic             busy, done, csN, sck;

  int nChecks = 0;
  int nFails = 0;
  logic [5:0] modelCfg = 6'h37;
  int lastFirstRise = -1;

  always #4 clk = ~clk;

  csseq_top #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCycles(reqCycles),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .busy(busy), .done(done), .csN(csN), .sck(sck)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int setupSteps(input logic [5:0] c); return c[5] ? 3 : 1; endfunction
  function automatic int holdSteps(input logic [5:0] c);  return c[4] ? 3 : 1; endfunction
  function automatic int gapSteps(input logic [5:0] c);   return 2 * (int'(c[3:0]) + 1); endfunction
  function automatic bit expSck(input int k, input int s, input int n);
    return (k >= s) && (k <= s + 2*n - 2) && (((k - s) % 2) == 0);
  endfunction

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  task automatic cfgWrite(input logic [5:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    modelCfg = v;
  endtask

  // Caller is at a negedge. Leaves at a negedge.
  task automatic runXfer(input int n, input int expWait, input bit chain,
                         input bit midWr, input logic [5:0] midVal);
    int s, h, m, d, w, last, firstRise, csRiseK, highCnt;
    int eCs, eDone, eBusy, eSck;
    s = setupSteps(modelCfg); h = holdSteps(modelCfg); m = gapSteps(modelCfg);
    d = s + 2*n - 2 + h;
    reqValid = 1'b1; reqCycles = CNT_W'(n);
    w = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      if (!csN) break;
      w++;
      if (w > 300) break;
    end
    if (expWait == 0) check(w == 0, "R2", "accept wait", w, 0);
    else              check(w == expWait, "R8", "held-off wait", w, expWait);
    reqValid = 1'b0;
    eCs = 0; eDone = 0; eBusy = 0; eSck = 0; firstRise = -1; csRiseK = -1; highCnt = 0;
    last = chain ? d : d + m + 1;
    for (int k = 0; k <= last; k++) begin
      if (k > 0) begin @(posedge clk); @(negedge clk); end
      if (midWr && k == 1) begin cfgWrEn = 1'b1; cfgWrData = midVal; end
      if (midWr && k == 2) cfgWrEn = 1'b0;
      if (sck === 1'b1) begin highCnt++; if (firstRise < 0) firstRise = k; end
      if (csN === 1'b1 && csRiseK < 0) csRiseK = k;
      if (csN !== (k >= d)) eCs++;
      if (sck !== expSck(k, s, n)) eSck++;
      if (done !== (k == d)) eDone++;
      if (!chain && busy !== (k < d + m)) eBusy++;
    end
    lastFirstRise = firstRise;
    check(firstRise == s, "R3", "first rising step", firstRise, s);
    check(highCnt == n && eSck == 0, "R4", "clock pulses", highCnt, n);
    check(csRiseK == d && eCs == 0, "R5", "chip-select release step", csRiseK, d);
    check(eDone == 0, "R7", "done pulse mismatches", eDone, 0);
    if (!chain) check(eBusy == 0, "R6", "busy mismatches", eBusy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish");
    finishRun();
  end

  initial begin
    int errs, n, n2, ch;
    logic [5:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1", "reset outputs {csN,sck,busy,done}", {csN, sck, busy, done}, 4'b1000);

    // R1 default configuration 0x37 drives the first frame
    runXfer(2, 0, 0, 0, 6'h0);
    check(lastFirstRise == 3, "R1", "default setup step", lastFirstRise, 3);

    cfgWrite(6'h00); runXfer(1, 0, 0, 0, 6'h0);
    cfgWrite(6'h0F); runXfer(3, 0, 0, 0, 6'h0);
    cfgWrite(6'h20); runXfer(4, 0, 0, 1, 6'h1F);
    runXfer(2, 0, 0, 0, 6'h0);
    check(lastFirstRise == 3, "R10", "setup after discarded write", lastFirstRise, 3);

    cfgWrite(6'h12);
    runXfer(2, 0, 1, 0, 6'h0);
    runXfer(3, gapSteps(modelCfg), 0, 0, 6'h0);

    // R9 zero count
    errs = 0;
    reqValid = 1'b1; reqCycles = '0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (csN !== 1'b1 || busy !== 1'b0) errs++;
    end
    reqValid = 1'b0;
    check(errs == 0, "R9", "zero-count disturbances", errs, 0);

    for (int it = 0; it < 25; it++) begin
      v  = 6'($urandom % 64);
      n  = 1 + int'($urandom % 6);
      n2 = 1 + int'($urandom % 4);
      ch = int'($urandom % 2);
      cfgWrite(v);
      if (ch == 1) begin
        runXfer(n, 0, 1, 0, 6'h0);
        runXfer(n2, gapSteps(modelCfg), 0, 0, 6'h0);
      end else begin
        runXfer(n, 0, 0, 0, 6'h0);
      end
    end
    finishRun();
  end

endmodule